// File: doc/BRIEF.md
# Control Register Write Handler

This block owns the three paging and mode control registers of an x86-style core (CR0, CR3, CR4) and the hidden mode flags that the rest of the pipeline reads from them. A single write port selects a register and supplies the new value. The handler decides what is actually stored, updates the derived flags, and sequences entry into and exit from long mode against the incoming EFER long-mode-enable bit. It keeps the long-mode-active bit (EFER.LMA) itself. When a write changes how addresses are translated, it raises a one-cycle TLB flush request.

The CR4 bits for the fast FP save, supervisor access prevention and protection keys are only kept when the matching CPUID feature input is present. Two bound-check flags are derived continuously. They come from the stored CR4 extended-save enable, an XCR0 state bit and a 2-bit bound configuration word. The word is chosen by the current privilege level. Reserved-bit faults are not raised here.

Top module: `cr_write_ctl`

## Requirements
- R1: A CR0 write (wr_sel=0) raises tlb_flush only if bit 31 (PG), bit 16 (WP) or bit 0 (PE) differs between the stored and written value.
- R2: A CR0 write that sets PG while stored PG is 0, efer_lme is 1 and stored CR4 bit 5 (PAE) is 0 is discarded: no register or flag changes and no flush.
- R3: A CR0 write that sets PG while stored PG is 0 and efer_lme is 1, with CR4.PAE set, is stored and sets efer_lma.
- R4: A CR0 write that clears stored PG while efer_lma is 1 clears efer_lma and hf_cs64, and pulses ip_clamp (truncate the instruction pointer to 32 bits) for one cycle.
- R5: The stored CR0 always has bit 4 (ET) set. hf_pe follows CR0 bit 0. hf_addseg becomes 1 on any accepted CR0 write with bit 0 clear, and stays 1 after later writes.
- R6: hf_fpu[2:0] equals stored CR0 bits 3:1 (TS, EM, MP).
- R7: A CR3 write (wr_sel=1) always stores the value and raises tlb_flush only when stored CR0.PG is 1. wr_sel=3 changes nothing.
- R8: A CR4 write (wr_sel=2) raises tlb_flush only if one of bits 4 (PSE), 5 (PAE), 7 (PGE), 12 (LA57), 20 (SMEP), 21 (SMAP) differs between the stored value and the value after gating.
- R9: On a CR4 write, bit 9 is cleared when feat_sse is 0, bit 21 when feat_smap is 0, and bit 22 when feat_pku is 0. hf_osfxsr and hf_smap follow stored CR4 bits 9 and 21.
- R10: bnd_en = CR4 bit 18 AND xcr0_bnd AND cfg[0], and bnd_pres = cfg[1]. cfg is bcfg_user when cpl is 3 and bcfg_sup otherwise.
- R11: After reset, CR0 is 0x00000010, CR3 and CR4 are 0, and efer_lma, hf_cs64, hf_addseg, tlb_flush and ip_clamp are 0.
- R12: Writes are visible on the outputs right after the clock edge that samples them. tlb_flush and ip_clamp are high for exactly the cycle following that edge.
- R13: cs_long_load sets hf_cs64 only while efer_lma is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 CR0, 1 CR3, 2 CR4 |
| wr_data | input | 32 | Write value |
| efer_lme | input | 1 | EFER long-mode enable |
| feat_sse | input | 1 | CPUID SSE present |
| feat_smap | input | 1 | CPUID supervisor-access-prevention present |
| feat_pku | input | 1 | CPUID protection keys present |
| cpl | input | 2 | Current privilege level |
| xcr0_bnd | input | 1 | XCR0 bound-config state enabled |
| bcfg_user | input | 2 | User bound config: bit0 enable, bit1 preserve |
| bcfg_sup | input | 2 | Supervisor bound config: bit0 enable, bit1 preserve |
| cs_long_load | input | 1 | A 64-bit code segment was loaded |
| cr0_q | output | 32 | Stored CR0 |
| cr3_q | output | 32 | Stored CR3 |
| cr4_q | output | 32 | Stored CR4 |
| efer_lma | output | 1 | Long mode active |
| hf_pe | output | 1 | Protected-mode flag |
| hf_addseg | output | 1 | Add-segment-base flag |
| hf_cs64 | output | 1 | 64-bit code flag |
| hf_fpu | output | 3 | {TS, EM, MP} trap flags |
| hf_osfxsr | output | 1 | Fast FP save enabled flag |
| hf_smap | output | 1 | Supervisor access prevention flag |
| bnd_en | output | 1 | Bound checking enabled |
| bnd_pres | output | 1 | Bound registers preserved |
| tlb_flush | output | 1 | One-cycle TLB flush request |
| ip_clamp | output | 1 | One-cycle request to truncate IP to 32 bits |

## Verification
CR0 is swept over all 64 combinations of PG, WP, PE, TS, EM and MP with long mode disabled. This separates the flush-relevant bits from the FP trap bits and shows the sticky add-segment flag. CR3 writes between those steps exercise the flush decision both with paging on and with paging off. CR4 is written with all-ones, all-zeros and single-bit patterns under all eight feature-input combinations, so gating and toggle-triggered flushes are told apart. A long-mode sequence covers the discarded entry with PAE off, entry with PAE on, the code-segment flag, and exit with its IP clamp. The bound flags are compared over every CPL, XCR0 bit and both configuration words, with the CR4 enable both set and clear.

// File: rtl/cr_pkg.sv
package cr_pkg;
    localparam int CR_W = 32;

    // CR0 bit positions
    localparam int B_PE  = 0;
    localparam int B_MP  = 1;
    localparam int B_TS  = 3;
    localparam int B_ET  = 4;
    localparam int B_WP  = 16;
    localparam int B_PG  = 31;
    // CR4 bit positions
    localparam int B_PSE    = 4;
    localparam int B_PAE    = 5;
    localparam int B_PGE    = 7;
    localparam int B_OSFXSR = 9;
    localparam int B_LA57   = 12;
    localparam int B_OSXSV  = 18;
    localparam int B_SMEP   = 20;
    localparam int B_SMAP   = 21;
    localparam int B_PKE    = 22;

    localparam logic [CR_W-1:0] CR0_XLAT_MASK =
        (CR_W'(1) << B_PG) | (CR_W'(1) << B_WP) | (CR_W'(1) << B_PE);
    localparam logic [CR_W-1:0] CR4_XLAT_MASK =
        (CR_W'(1) << B_PSE) | (CR_W'(1) << B_PAE) | (CR_W'(1) << B_PGE) |
        (CR_W'(1) << B_LA57) | (CR_W'(1) << B_SMEP) | (CR_W'(1) << B_SMAP);
    localparam logic [CR_W-1:0] CR0_RESET = CR_W'(1) << B_ET;

    typedef enum logic [1:0] {
        SEL_CR0 = 2'd0,
        SEL_CR3 = 2'd1,
        SEL_CR4 = 2'd2,
        SEL_NONE = 2'd3
    } cr_sel_e;

    typedef struct packed {
        logic            accept;
        logic            flush;
        logic            lma_set;
        logic            lma_clr;
        logic [CR_W-1:0] value;
    } cr0_upd_t;

    typedef struct packed {
        logic            flush;
        logic [CR_W-1:0] value;
    } cr4_upd_t;

    function automatic logic differs(input logic [CR_W-1:0] a,
                                     input logic [CR_W-1:0] b,
                                     input logic [CR_W-1:0] m);
        return ((a ^ b) & m) != '0;
    endfunction
endpackage

// File: rtl/cr0_unit.sv
module cr0_unit
    import cr_pkg::*;
(
    input  logic [CR_W-1:0] old_cr0,
    input  logic [CR_W-1:0] new_cr0,
    input  logic            lme,
    input  logic            pae,
    input  logic            lma,
    output cr0_upd_t        upd
);
    logic pg_on, pg_off, enter, drop;

    always_comb begin
        pg_on  = !old_cr0[B_PG] && new_cr0[B_PG];
        pg_off = old_cr0[B_PG] && !new_cr0[B_PG];
        enter  = pg_on && lme;
        drop   = enter && !pae;
        upd.accept  = !drop;
        upd.flush   = !drop && differs(old_cr0, new_cr0, CR0_XLAT_MASK);
        upd.lma_set = enter && pae;
        upd.lma_clr = pg_off && lma;
        upd.value   = new_cr0 | CR0_RESET;
    end
endmodule

// File: rtl/cr4_unit.sv
module cr4_unit
    import cr_pkg::*;
(
    input  logic [CR_W-1:0] old_cr4,
    input  logic [CR_W-1:0] new_cr4,
    input  logic            has_sse,
    input  logic            has_smap,
    input  logic            has_pku,
    output cr4_upd_t        upd
);
    localparam int NGATE = 3;
    localparam int GATE_POS [NGATE] = '{B_OSFXSR, B_SMAP, B_PKE};

    logic [NGATE-1:0] present;
    logic [CR_W-1:0]  kill;

    assign present = {has_pku, has_smap, has_sse};

    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        logic [CR_W-1:0] one;
        assign one = present[g] ? '0 : (CR_W'(1) << GATE_POS[g]);
    end

    assign kill = g_gate[0].one | g_gate[1].one | g_gate[2].one;

    always_comb begin
        upd.value = new_cr4 & ~kill;
        upd.flush = differs(old_cr4, upd.value, CR4_XLAT_MASK);
    end
endmodule

// File: rtl/bnd_unit.sv
module bnd_unit
    import cr_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  logic [CPL_W-1:0] cpl,
    input  logic             osxsave,
    input  logic             xcr0_bnd,
    input  logic [1:0]       cfg_user,
    input  logic [1:0]       cfg_sup,
    output logic             en,
    output logic             pres
);
    localparam logic [CPL_W-1:0] USER_LVL = '1;
    logic [1:0] cfg;

    always_comb begin
        cfg  = (cpl == USER_LVL) ? cfg_user : cfg_sup;
        en   = osxsave && xcr0_bnd && cfg[0];
        pres = cfg[1];
    end
endmodule

// File: rtl/cr_write_ctl.sv
module cr_write_ctl
    import cr_pkg::*;
#(
    parameter int CR3_W = 32,
    parameter int CPL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CR_W-1:0]  wr_data,
    input  logic             efer_lme,
    input  logic             feat_sse,
    input  logic             feat_smap,
    input  logic             feat_pku,
    input  logic [CPL_W-1:0] cpl,
    input  logic             xcr0_bnd,
    input  logic [1:0]       bcfg_user,
    input  logic [1:0]       bcfg_sup,
    input  logic             cs_long_load,
    output logic [CR_W-1:0]  cr0_q,
    output logic [CR3_W-1:0] cr3_q,
    output logic [CR_W-1:0]  cr4_q,
    output logic             efer_lma,
    output logic             hf_pe,
    output logic             hf_addseg,
    output logic             hf_cs64,
    output logic [2:0]       hf_fpu,
    output logic             hf_osfxsr,
    output logic             hf_smap,
    output logic             bnd_en,
    output logic             bnd_pres,
    output logic             tlb_flush,
    output logic             ip_clamp
);
    cr_sel_e  sel;
    cr0_upd_t u0;
    cr4_upd_t u4;
    logic     w0, w3, w4;

    assign sel = cr_sel_e'(wr_sel);
    assign w0  = wr_en && (sel == SEL_CR0);
    assign w3  = wr_en && (sel == SEL_CR3);
    assign w4  = wr_en && (sel == SEL_CR4);

    cr0_unit u_cr0 (
        .old_cr0 (cr0_q),
        .new_cr0 (wr_data),
        .lme     (efer_lme),
        .pae     (cr4_q[B_PAE]),
        .lma     (efer_lma),
        .upd     (u0)
    );

    cr4_unit u_cr4 (
        .old_cr4  (cr4_q),
        .new_cr4  (wr_data),
        .has_sse  (feat_sse),
        .has_smap (feat_smap),
        .has_pku  (feat_pku),
        .upd      (u4)
    );

    bnd_unit #(.CPL_W(CPL_W)) u_bnd (
        .cpl      (cpl),
        .osxsave  (cr4_q[B_OSXSV]),
        .xcr0_bnd (xcr0_bnd),
        .cfg_user (bcfg_user),
        .cfg_sup  (bcfg_sup),
        .en       (bnd_en),
        .pres     (bnd_pres)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr0_q     <= CR0_RESET;
            cr3_q     <= '0;
            cr4_q     <= '0;
            efer_lma  <= 1'b0;
            hf_cs64   <= 1'b0;
            hf_addseg <= 1'b0;
            tlb_flush <= 1'b0;
            ip_clamp  <= 1'b0;
        end else begin
            tlb_flush <= (w0 && u0.flush) || (w3 && cr0_q[B_PG]) ||
                         (w4 && u4.flush);
            ip_clamp  <= w0 && u0.accept && u0.lma_clr;

            if (w0 && u0.accept) begin
                cr0_q <= u0.value;
                if (!wr_data[B_PE]) hf_addseg <= 1'b1;
                if (u0.lma_set) efer_lma <= 1'b1;
                if (u0.lma_clr) efer_lma <= 1'b0;
            end

            if (w0 && u0.accept && u0.lma_clr)
                hf_cs64 <= 1'b0;
            else if (cs_long_load && efer_lma)
                hf_cs64 <= 1'b1;

            if (w3) cr3_q <= wr_data[CR3_W-1:0];
            if (w4) cr4_q <= u4.value;
        end
    end

    assign hf_pe     = cr0_q[B_PE];
    assign hf_fpu    = cr0_q[B_TS:B_MP];
    assign hf_osfxsr = cr4_q[B_OSFXSR];
    assign hf_smap   = cr4_q[B_SMAP];
endmodule

// File: rtl/cr_write_ctl_chk.sv
module cr_write_ctl_chk
    import cr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [CR_W-1:0] wr_data,
    input logic            efer_lme,
    input logic            feat_pku,
    input logic [CR_W-1:0] cr0_q,
    input logic [CR_W-1:0] cr4_q,
    input logic            efer_lma,
    input logic            hf_cs64,
    input logic            bnd_en,
    input logic            tlb_flush,
    input logic            ip_clamp
);
    logic w0;
    assign w0 = wr_en && (wr_sel == 2'd0);

    AST_CR0_QUIET: assert property (@(posedge clk) disable iff (rst)
        (w0 && ((wr_data ^ cr0_q) & CR0_XLAT_MASK) == '0) |=> !tlb_flush); // R1

    AST_PG_DROP: assert property (@(posedge clk) disable iff (rst)
        (w0 && !cr0_q[B_PG] && wr_data[B_PG] && efer_lme && !cr4_q[B_PAE])
        |=> ($stable(cr0_q) && !tlb_flush && !efer_lma)); // R2

    AST_LM_ENTER: assert property (@(posedge clk) disable iff (rst)
        (w0 && !cr0_q[B_PG] && wr_data[B_PG] && efer_lme && cr4_q[B_PAE])
        |=> efer_lma); // R3

    AST_LM_EXIT: assert property (@(posedge clk) disable iff (rst)
        (w0 && cr0_q[B_PG] && !wr_data[B_PG] && efer_lma)
        |=> (!efer_lma && !hf_cs64 && ip_clamp)); // R4

    AST_CR3_NOFLUSH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && !cr0_q[B_PG]) |=> !tlb_flush); // R7

    AST_PKE_GATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !feat_pku) |=> !cr4_q[B_PKE]); // R9

    AST_BND_NEEDS_OSX: assert property (@(posedge clk) disable iff (rst)
        bnd_en |-> cr4_q[B_OSXSV]); // R10

    AST_CLAMP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !ip_clamp); // R12
endmodule

bind cr_write_ctl cr_write_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .efer_lme  (efer_lme),
    .feat_pku  (feat_pku),
    .cr0_q     (cr0_q),
    .cr4_q     (cr4_q),
    .efer_lma  (efer_lma),
    .hf_cs64   (hf_cs64),
    .bnd_en    (bnd_en),
    .tlb_flush (tlb_flush),
    .ip_clamp  (ip_clamp)
);

// File: tb/sim_cr_write_ctl.sv
module sim_cr_write_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        efer_lme = 1'b0;
    logic        feat_sse = 1'b1, feat_smap = 1'b1, feat_pku = 1'b1;
    logic [1:0]  cpl = 2'd0;
    logic        xcr0_bnd = 1'b0;
    logic [1:0]  bcfg_user = 2'd0, bcfg_sup = 2'd0;
    logic        cs_long_load = 1'b0;
    logic [31:0] cr0_q, cr3_q, cr4_q;
    logic        efer_lma, hf_pe, hf_addseg, hf_cs64, hf_osfxsr, hf_smap;
    logic [2:0]  hf_fpu;
    logic        bnd_en, bnd_pres, tlb_flush, ip_clamp;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    cr_write_ctl u0 (.*);

    // model state
    logic [31:0] m_cr0 = 32'h10, m_cr3 = 0, m_cr4 = 0;
    logic m_lma = 0, m_cs64 = 0, m_addseg = 0, m_flush = 0, m_clamp = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "cr0", cr0_q, m_cr0);
        chk(req, "cr3", cr3_q, m_cr3);
        chk(req, "cr4", cr4_q, m_cr4);
        chk(req, "lma", 32'(efer_lma), 32'(m_lma));
        chk(req, "cs64", 32'(hf_cs64), 32'(m_cs64));
        chk(req, "addseg", 32'(hf_addseg), 32'(m_addseg));
        chk("R5", "pe", 32'(hf_pe), 32'(m_cr0[0]));
        chk("R6", "fpu", 32'(hf_fpu), 32'(m_cr0[3:1]));
        chk("R9", "osfxsr", 32'(hf_osfxsr), 32'(m_cr4[9]));
        chk("R9", "smap", 32'(hf_smap), 32'(m_cr4[21]));
        chk(req, "flush", 32'(tlb_flush), 32'(m_flush));
        chk(req, "clamp", 32'(ip_clamp), 32'(m_clamp));
    endtask

    task automatic model_write(input logic [1:0] sel, input logic [31:0] d);
        logic [31:0] g;
        m_flush = 0; m_clamp = 0;
        if (sel == 2'd0) begin
            if (!m_cr0[31] && d[31] && efer_lme && !m_cr4[5]) begin
                // R2 discarded
            end else begin
                m_flush = ((m_cr0 ^ d) & 32'h8001_0001) != 0;
                if (!m_cr0[31] && d[31] && efer_lme) m_lma = 1;
                else if (m_cr0[31] && !d[31] && m_lma) begin
                    m_lma = 0; m_cs64 = 0; m_clamp = 1;
                end
                m_cr0 = d | 32'h10;
                if (!d[0]) m_addseg = 1;
            end
        end else if (sel == 2'd1) begin
            m_flush = m_cr0[31];
            m_cr3 = d;
        end else if (sel == 2'd2) begin
            g = d;
            if (!feat_sse)  g[9]  = 0;
            if (!feat_smap) g[21] = 0;
            if (!feat_pku)  g[22] = 0;
            m_flush = ((m_cr4 ^ g) & 32'h0030_10B0) != 0;
            m_cr4 = g;
        end
    endtask

    // Drive at negedge, check after the sampling edge, then check pulse ends.
    task automatic wr(input string req, input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        model_write(sel, d);
        @(negedge clk);
        wr_en = 0;
        chk_all(req);
        @(negedge clk);
        m_flush = 0; m_clamp = 0;
        chk("R12", "pulse end flush", 32'(tlb_flush), 0);
        chk("R12", "pulse end clamp", 32'(ip_clamp), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_all("R11");

        // CR0 sweep with long mode disabled; CR3 writes interleaved
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = 32'h0;
            d[31] = i[5]; d[16] = i[4]; d[3:1] = i[3:1]; d[0] = i[0];
            d[8] = i[2]; // a bit outside the flush set
            wr("R1", 2'd0, d);
            if (i % 4 == 0) wr("R7", 2'd1, 32'hA5A5_0000 + i);
        end
        wr("R7", 2'd3, 32'hFFFF_FFFF); // ignored select
        wr("R7", 2'd1, 32'h1234_5000);

        // CR4 sweep under all feature combinations
        for (int f = 0; f < 8; f++) begin
            feat_sse = f[0]; feat_smap = f[1]; feat_pku = f[2];
            wr("R9", 2'd2, 32'hFFFF_FFFF);
            wr("R8", 2'd2, 32'hFFFF_FFFF);
            wr("R8", 2'd2, 32'h0000_0000);
            wr("R8", 2'd2, 32'h0004_0200);
            wr("R8", 2'd2, 32'h0000_1000);
        end
        feat_sse = 1; feat_smap = 1; feat_pku = 1;

        // Long-mode sequencing
        wr("R4", 2'd0, 32'h0000_0001);      // paging off
        @(negedge clk);
        cs_long_load = 1; @(negedge clk); cs_long_load = 0;
        chk("R13", "cs64 without lma", 32'(hf_cs64), 0);
        efer_lme = 1;
        wr("R4", 2'd2, 32'h0000_0000);      // PAE off
        wr("R2", 2'd0, 32'h8000_0001);      // discarded
        wr("R4", 2'd2, 32'h0000_0020);      // PAE on
        wr("R3", 2'd0, 32'h8000_0001);      // enter long mode
        chk("R3", "lma after entry", 32'(efer_lma), 1);
        cs_long_load = 1; @(negedge clk); cs_long_load = 0; m_cs64 = 1;
        chk("R13", "cs64 with lma", 32'(hf_cs64), 1);
        wr("R7", 2'd1, 32'hCAFE_F000);      // paging on: flush
        wr("R4", 2'd0, 32'h0000_0011);      // exit long mode
        chk("R4", "cs64 after exit", 32'(hf_cs64), 0);
        efer_lme = 0;

        // Bound flags over CPL, XCR0 bit and both config words
        for (int o = 0; o < 2; o++) begin
            wr("R10", 2'd2, o ? 32'h0004_0000 : 32'h0);
            for (int v = 0; v < 128; v++) begin
                logic [1:0] cf;
                cpl = v[1:0]; xcr0_bnd = v[2];
                bcfg_user = v[4:3]; bcfg_sup = v[6:5];
                #1;
                cf = (v[1:0] == 2'd3) ? v[4:3] : v[6:5];
                chk("R10", "bnd_en", 32'(bnd_en), 32'(o[0] & v[2] & cf[0]));
                chk("R10", "bnd_pres", 32'(bnd_pres), 32'(cf[1]));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule